// File: doc/BRIEF.md
# Multi-line transmit DMA scheduler

This block feeds a bank of serial transmitters from memory. Each line has its own current address, its own byte count and its own line-parameter word. All three sit behind a single register window. A line-select field in the control register decides which line's copy the window shows. Software loads a line's address and its negative byte count, then sets that line's bit in the active mask. From then on the block fetches the line's bytes one at a time over a simple byte-read memory port. It hands each byte to the line's transmitter whenever that transmitter's holding register is empty.

Lines that are ready to send share the memory port in round-robin order, one fetch per grant. Each fetched byte advances the line's address and brings its count one step closer to zero. When the count reaches zero, hardware clears the line's active bit and flags a transmit-done event, which can raise an interrupt. To abort a line early, software rewrites its count to all ones. The address register then shows how far the line got. The block also reports memory errors and provides a master clear.

Top module: `txdma_sched`

## Requirements
- R1: The low log2(NLINES) bits of the line-select field, control bits 3:0, pick the line whose count (register offset 2), address (offset 3) and parameter word (offset 4) are read and written through the window. Offset 0 is control and offset 1 is the active mask.
- R2: A write to the address register stores the 16 written bits as address bits 15:0. Address bits 17:16 are taken from control bits 5:4 at the time of that write. Each fetch presents the full 18-bit address on mem_addr.
- R3: The count holds the two's complement negative of the bytes left and is incremented once per fetched byte. When it reaches zero, the line's active bit clears and control bit 15 (done flag) sets. irq is high exactly while bit 15 and bit 13 (done enable) are both set.
- R4: Writing the active mask sets each line whose bit is written as one. Bits written as zero change nothing.
- R5: Eligible lines are granted in round-robin order, starting with the line after the last one serviced and wrapping from NLINES-1 to 0. Each grant fetches exactly one byte.
- R6: A line is fetched only while its tx_empty input is high. Other eligible lines keep being served meanwhile.
- R7: An active line whose count is zero causes no fetch. Its active bit clears and the done flag sets within two cycles.
- R8: If software writes 16'hFFFF to the count of an active line, that line delivers at most one more byte and then stops. Its address register then reads one past the last byte fetched.
- R9: A memory response with mem_err set delivers no byte, clears the line's active bit, leaves its address and count unchanged and sets control bit 10. Writing control with bit 8 set clears bit 10.
- R10: Writing control with bit 11 set clears every line's state, the active mask, the control fields and any fetch in progress.
- R11: The parameter word keeps only bits 14:0 except bit 3: length code in 1:0, two-stop in 2, parity enable in 4, odd parity in 5, receive speed in 9:6, transmit speed in 13:10 and half duplex in 14. Line n's word appears on line_cfg[16n+15:16n].
- R12: Writing control with bit 15 at zero clears the done flag. Writing it as one never sets the flag.
- R13: mem_req stays high with a stable mem_addr until mem_ack. One cycle after a good ack, tx_load pulses one-hot for the line and tx_data carries the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| irq | output | 1 | Transmit-done interrupt request |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 18 | Byte read address |
| mem_ack | input | 1 | Read response valid |
| mem_err | input | 1 | Response targets no memory |
| mem_rdata | input | 8 | Read byte |
| tx_empty | input | NLINES | Per-line transmitter holding register empty |
| tx_load | output | NLINES | One-hot byte load strobe |
| tx_data | output | 8 | Byte for the strobed line |
| line_cfg | output | 16*NLINES | Parameter word of every line |

## Verification
The bench builds the block with NLINES = 8. With 8 lines the three-bit select field and the round-robin wrap from line 7 back to line 0 are reached after only a few grants. It also makes it easy to start two lines in the same write so that their bytes interleave. The memory model derives each byte from its address and fails any address whose bits 17:16 are both one. This puts the address extension, the error path and the abort offset all within reach of a short run.

// File: rtl/txdma_sched.sv
module txdma_sched #(
  parameter int NLINES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [2:0]            reg_addr,
  input  logic [15:0]           reg_wdata,
  output logic [15:0]           reg_rdata,
  output logic                  irq,
  output logic                  mem_req,
  output logic [17:0]           mem_addr,
  input  logic                  mem_ack,
  input  logic                  mem_err,
  input  logic [7:0]            mem_rdata,
  input  logic [NLINES-1:0]     tx_empty,
  output logic [NLINES-1:0]     tx_load,
  output logic [7:0]            tx_data,
  output logic [16*NLINES-1:0]  line_cfg
);
  localparam int LS = (NLINES > 1) ? $clog2(NLINES) : 1;
  localparam logic [14:0] PAR_MASK = 15'h7FF7;

  logic [3:0]        sel_q;
  logic [1:0]        ext_q;
  logic              tie_q, ti_q, nxm_q;
  logic [NLINES-1:0] act_q;
  logic [17:0]       addr_q [NLINES];
  logic [15:0]       cnt_q  [NLINES];
  logic [14:0]       par_q  [NLINES];
  logic              busy_q;
  logic [LS-1:0]     cur_q, last_q;
  logic [NLINES-1:0] load_q;
  logic [7:0]        data_q;

  wire [LS-1:0] wl      = sel_q[LS-1:0];
  wire          wr_ctrl = reg_we && reg_addr == 3'd0;
  wire          wr_act  = reg_we && reg_addr == 3'd1;
  wire          wr_cnt  = reg_we && reg_addr == 3'd2;
  wire          wr_adr  = reg_we && reg_addr == 3'd3;
  wire          wr_par  = reg_we && reg_addr == 3'd4;
  wire          mclr    = wr_ctrl && reg_wdata[11];
  wire          ack_ok  = busy_q && mem_ack && !mem_err;
  wire          ack_bad = busy_q && mem_ack && mem_err;

  logic [NLINES-1:0] cnt_zero, elig, zdone, cur_hot;
  logic [LS-1:0]     pick;
  logic              found;
  logic [15:0]       next_cnt;
  logic              fin;

  always_comb begin
    for (int i = 0; i < NLINES; i++) begin
      cnt_zero[i] = cnt_q[i] == 16'd0;
      cur_hot[i]  = busy_q && cur_q == LS'(i);
    end
    elig  = act_q & tx_empty & ~cnt_zero & {NLINES{~busy_q}};
    zdone = act_q & cnt_zero & ~cur_hot;
  end

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int k = 1; k <= NLINES; k++) begin
      if (!found && elig[(int'(last_q) + k) % NLINES]) begin
        found = 1'b1;
        pick  = LS'((int'(last_q) + k) % NLINES);
      end
    end
  end

  assign next_cnt = (wr_cnt && wl == cur_q) ? reg_wdata + 16'd1 : cnt_q[cur_q] + 16'd1;
  assign fin      = ack_ok && next_cnt == 16'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0; ext_q <= '0; tie_q <= 1'b0; ti_q <= 1'b0; nxm_q <= 1'b0;
    end else if (mclr) begin
      sel_q <= '0; ext_q <= '0; tie_q <= 1'b0; ti_q <= 1'b0; nxm_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        sel_q <= reg_wdata[3:0];
        ext_q <= reg_wdata[5:4];
        tie_q <= reg_wdata[13];
      end
      ti_q  <= (ti_q && !(wr_ctrl && !reg_wdata[15])) || fin || (zdone != '0);
      nxm_q <= (nxm_q && !(wr_ctrl && reg_wdata[8])) || ack_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      for (int i = 0; i < NLINES; i++) begin
        addr_q[i] <= '0; cnt_q[i] <= '0; par_q[i] <= '0;
      end
    end else if (mclr) begin
      act_q <= '0;
      for (int i = 0; i < NLINES; i++) begin
        addr_q[i] <= '0; cnt_q[i] <= '0; par_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NLINES; i++) begin
        if (ack_ok && cur_q == LS'(i))
          cnt_q[i] <= next_cnt;
        else if (wr_cnt && wl == LS'(i))
          cnt_q[i] <= reg_wdata;
        if (wr_adr && wl == LS'(i))
          addr_q[i] <= {ext_q, reg_wdata};
        else if (ack_ok && cur_q == LS'(i))
          addr_q[i] <= addr_q[i] + 18'd1;
        if (wr_par && wl == LS'(i))
          par_q[i] <= reg_wdata[14:0] & PAR_MASK;
        if ((cur_q == LS'(i) && (fin || ack_bad)) || zdone[i])
          act_q[i] <= 1'b0;
        if (wr_act && reg_wdata[i % 16])
          act_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; cur_q <= '0; last_q <= LS'(NLINES - 1);
      load_q <= '0; data_q <= '0;
    end else if (mclr) begin
      busy_q <= 1'b0; cur_q <= '0; last_q <= LS'(NLINES - 1);
      load_q <= '0; data_q <= '0;
    end else begin
      load_q <= ack_ok ? cur_hot : '0;
      if (ack_ok) data_q <= mem_rdata;
      if (busy_q && mem_ack) begin
        busy_q <= 1'b0;
        last_q <= cur_q;
      end else if (!busy_q && found) begin
        busy_q <= 1'b1;
        cur_q  <= pick;
      end
    end
  end

  assign mem_req  = busy_q;
  assign mem_addr = addr_q[cur_q];
  assign tx_load  = load_q;
  assign tx_data  = data_q;
  assign irq      = ti_q && tie_q;

  for (genvar g = 0; g < NLINES; g++) begin : g_cfg
    assign line_cfg[16*g +: 16] = {1'b0, par_q[g]};
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {ti_q, 1'b0, tie_q, 2'b00, nxm_q, 4'b0000, ext_q, sel_q};
      3'd1:    reg_rdata = 16'(act_q);
      3'd2:    reg_rdata = cnt_q[wl];
      3'd3:    reg_rdata = addr_q[wl][15:0];
      3'd4:    reg_rdata = {1'b0, par_q[wl]};
      default: reg_rdata = 16'h0000;
    endcase
  end

  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n || mclr)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  p_load_onehot_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_load));
  p_load_after_ack_r13: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load != '0 |-> $past(mem_ack && !mem_err && mem_req));
  p_load_active_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load != '0 |-> (tx_load & $past(act_q)) == tx_load);
  p_grant_empty_r6: assert property (@(posedge clk) disable iff (!rst_n || mclr)
    $rose(mem_req) |-> ($past(tx_empty) & cur_hot) == cur_hot);
  p_no_err_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_ack && mem_err) |-> tx_load == '0);
endmodule

// File: tb/txdma_sched_tb_top.sv
`timescale 1ns/1ps
module txdma_sched_tb_top;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic irq, mem_req, mem_ack = 1'b0, mem_err = 1'b0;
  logic [17:0] mem_addr;
  logic [7:0] mem_rdata = '0, tx_data;
  logic [N-1:0] tx_empty, tx_load, hold = '0;
  logic [16*N-1:0] line_cfg;
  int n_checks = 0, n_errors = 0;
  logic [15:0] exp_q[$];
  bit done = 0;

  always #2 clk = ~clk;
  assign tx_empty = ~hold;

  txdma_sched #(.NLINES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_err(mem_err), .mem_rdata(mem_rdata), .tx_empty(tx_empty),
    .tx_load(tx_load), .tx_data(tx_data), .line_cfg(line_cfg));

  function automatic logic [7:0] mbyte(input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {6'd0, a[17:16]};
  endfunction

  always @(negedge clk) begin
    mem_ack   = mem_req && !mem_ack;
    mem_err   = mem_ack && mem_addr[17:16] == 2'b11;
    mem_rdata = mbyte(mem_addr);
  end

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && tx_load != '0) begin
    logic [15:0] e;
    logic [15:0] g;
    g = {4'd0, 4'($clog2(int'(tx_load))), tx_data};
    if (exp_q.size() == 0) e = 16'hDEAD; else e = exp_q.pop_front();
    chk("R13 R5 byte delivery (line,data)", g, e);
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [15:0] exp);
    @(negedge clk); reg_addr = a; #0.5;
    chk(req, reg_rdata, exp);
  endtask

  task automatic setup(input int l, input int ext, input logic [15:0] a, input logic [15:0] c);
    wr(3'd0, 16'hA000 | 16'(ext << 4) | 16'(l));
    wr(3'd3, a);
    wr(3'd2, c);
  endtask

  task automatic expect_byte(input int l, input logic [17:0] a);
    exp_q.push_back({4'd0, 4'(l), mbyte(a)});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(2);
    rd("R10 reset control", 3'd0, 16'h0000);
    chk("R13 reset idle", {14'd0, mem_req, irq}, 16'h0000);

    wr(3'd0, 16'h2003); wr(3'd4, 16'hFFFF);
    rd("R11 param mask", 3'd4, 16'h7FF7);
    wr(3'd0, 16'h2005); wr(3'd4, 16'h0A53);
    wr(3'd0, 16'h2003);
    rd("R1 window reselect", 3'd4, 16'h7FF7);
    chk("R11 line_cfg 3", line_cfg[48 +: 16], 16'h7FF7);
    chk("R11 line_cfg 5", line_cfg[80 +: 16], 16'h0A53);

    setup(2, 1, 16'h0100, 16'hFFFD);
    expect_byte(2, 18'h10100); expect_byte(2, 18'h10101); expect_byte(2, 18'h10102);
    wr(3'd1, 16'h0004); idle(30);
    rd("R3 active cleared", 3'd1, 16'h0000);
    rd("R3 count zero", 3'd2, 16'h0000);
    rd("R2 address advanced", 3'd3, 16'h0103);
    rd("R3 done flag", 3'd0, 16'hA012);
    chk("R3 irq", {15'd0, irq}, 16'h0001);

    wr(3'd0, 16'h2012);
    rd("R12 done cleared", 3'd0, 16'h2012);
    chk("R12 irq low", {15'd0, irq}, 16'h0000);
    wr(3'd0, 16'hA012);
    rd("R12 one does not set", 3'd0, 16'h2012);

    setup(4, 0, 16'h0300, 16'hFFFE);
    setup(1, 0, 16'h0400, 16'hFFFE);
    expect_byte(4, 18'h00300); expect_byte(1, 18'h00400);
    expect_byte(4, 18'h00301); expect_byte(1, 18'h00401);
    wr(3'd1, 16'h0012); idle(30);
    chk("R5 round robin drained", 16'(exp_q.size()), 16'h0000);

    setup(6, 0, 16'h0500, 16'hFFFF);
    setup(0, 0, 16'h0600, 16'hFFFF);
    expect_byte(6, 18'h00500); expect_byte(0, 18'h00600);
    wr(3'd1, 16'h0041); idle(20);
    chk("R5 wrap drained", 16'(exp_q.size()), 16'h0000);

    hold = 8'h08;
    setup(3, 0, 16'h0700, 16'hFFFE);
    setup(5, 0, 16'h0800, 16'hFFFF);
    expect_byte(5, 18'h00800);
    wr(3'd1, 16'h0028); wr(3'd1, 16'h0000); idle(20);
    rd("R6 held line waits, R4 zero write no effect", 3'd1, 16'h0008);
    chk("R6 only free line served", 16'(exp_q.size()), 16'h0000);
    expect_byte(3, 18'h00700); expect_byte(3, 18'h00701);
    hold = 8'h00; idle(20);
    rd("R6 released line done", 3'd1, 16'h0000);

    wr(3'd0, 16'h2007);
    setup(7, 0, 16'h0000, 16'h0000);
    wr(3'd1, 16'h0080); idle(3);
    rd("R7 zero count completes", 3'd1, 16'h0000);
    rd("R7 done flag", 3'd0, 16'hA007);

    hold = 8'h04;
    setup(2, 0, 16'h0200, 16'hFFCE);
    wr(3'd1, 16'h0004); idle(10);
    wr(3'd2, 16'hFFFF);
    expect_byte(2, 18'h00200);
    hold = 8'h00; idle(20);
    rd("R8 abort stopped", 3'd1, 16'h0000);
    rd("R8 abort address", 3'd3, 16'h0201);
    rd("R8 abort count", 3'd2, 16'h0000);

    setup(4, 3, 16'h0010, 16'hFFFE);
    wr(3'd1, 16'h0010); idle(10);
    rd("R9 error flag", 3'd0, 16'hA434);
    rd("R9 line dropped", 3'd1, 16'h0000);
    rd("R9 address kept", 3'd3, 16'h0010);
    rd("R9 count kept", 3'd2, 16'hFFFE);
    wr(3'd0, 16'h2104);
    rd("R9 error cleared", 3'd0, 16'h2004);

    hold = 8'h02;
    setup(1, 0, 16'h0900, 16'hFFFB);
    wr(3'd4, 16'h1234);
    wr(3'd1, 16'h0002); idle(5);
    wr(3'd0, 16'h0800);
    rd("R10 control cleared", 3'd0, 16'h0000);
    rd("R10 active cleared", 3'd1, 16'h0000);
    wr(3'd0, 16'h0001);
    rd("R10 count cleared", 3'd2, 16'h0000);
    rd("R10 param cleared", 3'd4, 16'h0000);
    hold = 8'h00; idle(10);
    chk("R10 no stray bytes", 16'(exp_q.size()), 16'h0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule